// File: doc/BRIEF.md
# Stacked Interrupt Status Register

This block is the host-facing interrupt summary of a bus-mastering peripheral that runs its own script processor. It gathers event pulses from two groups, a DMA/script group and a bus-interface group. Each group has a visible status word that the host reads, and a hidden pending word behind it. The block reports one summary pending bit per group and drives a registered interrupt request. The host can read the summary byte at any time without disturbing the engine. It can therefore poll for work while the interrupt request is masked off.

While either summary bit is high, both visible status words are frozen. New events collect in the pending words. When the host reads one of the detailed status words, that word is replaced by its pending word. If the pending word held anything, the summary bit rises again, and so does the interrupt. The same byte also carries three host-writable control flags (abort, software reset, signal-process) and a registered copy of the link-connected input.

Top module: `stacked_irq_status`

## Requirements
- R1: After a cycle with `rst_n` low, `istat`, `dma_stat`, `bus_stat` and `irq` are all 0.
- R2: While the gate is open (both summary bits low), an event bit on `dma_evt` or `bus_evt` is ORed into the matching visible status word at the next clock edge, together with any pending bits.
- R3: `istat[0]` equals the OR of `dma_stat`. `istat[1]` equals the OR of `bus_stat & ~bus_evt_mask`. Both are combinational from the visible state and the mask.
- R4: While `istat[1]` or `istat[0]` is high, a visible status word does not change unless its own read strobe is given. Events that arrive in that time are ORed into that group's pending word.
- R5: A read strobe (`dma_stat_rd` or `bus_stat_rd`) loads the matching visible word from its pending word at the next edge. A non-empty pending word therefore raises the summary bit again.
- R6: An event that arrives in the same cycle as its group's read strobe is placed in the pending word and is not lost. It reaches the visible word once the gate is open.
- R7: `irq` is a register, loaded each edge with (`istat[1]` OR `istat[0]`) AND NOT `irq_mask`.
- R8: `istat[7]` (abort) is set at the next edge by `host_wr` with `host_wdata[7]`=1. It is cleared by `abort_ack`, and the write wins if both happen in one cycle. A write with bit 7 at 0 leaves it unchanged.
- R9: `istat[5]` (signal-process) behaves like R8, with `host_wdata[5]` and `sigp_ack`.
- R10: `istat[6]` (software reset) is loaded from `host_wdata[6]` on each `host_wr` and holds its value otherwise.
- R11: `istat[3]` is `link_connected` delayed by one edge. `istat[4]` and `istat[2]` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dma_evt | input | DMA_W | DMA/script event pulses, one per bit |
| bus_evt | input | BUS_W | Bus-interface event pulses, one per bit |
| bus_evt_mask | input | BUS_W | Bits excluded from the bus summary bit |
| irq_mask | input | 1 | Global interrupt mask |
| dma_stat_rd | input | 1 | Host read-clear of the DMA status word |
| bus_stat_rd | input | 1 | Host read-clear of the bus status word |
| host_wr | input | 1 | Host write strobe for the control flags |
| host_wdata | input | 8 | Host write data |
| abort_ack | input | 1 | Engine acknowledge that clears abort |
| sigp_ack | input | 1 | Engine acknowledge that clears signal-process |
| link_connected | input | 1 | Link-connected level |
| istat | output | 8 | Summary byte |
| dma_stat | output | DMA_W | Visible DMA status word |
| bus_stat | output | BUS_W | Visible bus status word |
| irq | output | 1 | Registered interrupt request |

## Verification
Visible status words, control flags and the link bit are due one edge after the stimulus that moves them. The summary bits follow the visible words in the same cycle. `irq` is due one edge after the summary bits it reflects. A promoted pending word therefore shows on `irq` two edges after the read strobe. The bench drives inputs just after a falling edge and advances a reference model once per rising edge. It compares every output at the next falling edge, so each check sees exactly the state one edge after its stimulus.

// File: rtl/stacked_irq_pkg.sv
// Shared bit positions of the summary byte.
// Assumes an 8-bit host-visible summary register.
package stacked_irq_pkg;
    localparam int STAT_W       = 8;
    localparam int STAT_ABORT   = 7;
    localparam int STAT_SWRST   = 6;
    localparam int STAT_SIGNAL  = 5;
    localparam int STAT_LINK    = 3;
    localparam int STAT_BUSPEND = 1;
    localparam int STAT_DMAPEND = 0;
endpackage

// File: rtl/irq_stack_stage.sv
// Two-stage event store for one source group: a visible word and a pending word.
// Assumes `gate_closed` comes from the global summary and `rd_clr` is a one-cycle pulse.
module irq_stack_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         gate_closed,
    input  logic         rd_clr,
    output logic [W-1:0] vis
);
    logic [W-1:0] pend;

    // Updates the visible and pending words from events, gate and read-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vis  <= '0;
            pend <= '0;
        end else if (rd_clr) begin
            vis  <= pend;
            pend <= evt;
        end else if (gate_closed) begin
            pend <= pend | evt;
        end else begin
            vis  <= vis | pend | evt;
            pend <= '0;
        end
    end

    // R4
    hold_when_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_closed && !rd_clr) |=> $stable(vis));
    // R5
    promote_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> (vis == $past(pend)));
    // R2
    capture_when_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_closed && !rd_clr) |=> ((vis & $past(evt)) == $past(evt)));
endmodule

// File: rtl/irq_ctrl_flags.sv
// Host-writable control flags and the registered link bit.
// Assumes acknowledges are single-cycle pulses from the engine.
module irq_ctrl_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic       wr_abort,
    input  logic       wr_swrst,
    input  logic       wr_signal,
    input  logic       abort_ack,
    input  logic       sigp_ack,
    input  logic       link_connected,
    output logic       abort_q,
    output logic       swrst_q,
    output logic       signal_q,
    output logic       link_q
);
    // Abort: set by host write, cleared by acknowledge; the write wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                    abort_q <= 1'b0;
        else if (host_wr && wr_abort)  abort_q <= 1'b1;
        else if (abort_ack)            abort_q <= 1'b0;
    end

    // Signal-process: same set and clear rule as abort.
    always_ff @(posedge clk) begin
        if (!rst_n)                    signal_q <= 1'b0;
        else if (host_wr && wr_signal) signal_q <= 1'b1;
        else if (sigp_ack)             signal_q <= 1'b0;
    end

    // Software reset: loaded from every write, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       swrst_q <= 1'b0;
        else if (host_wr) swrst_q <= wr_swrst;
    end

    // Link bit: one-cycle registered copy of the input level.
    always_ff @(posedge clk) begin
        if (!rst_n) link_q <= 1'b0;
        else        link_q <= link_connected;
    end

    // R8
    abort_ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_ack && !(host_wr && wr_abort)) |=> !abort_q);
    // R9
    signal_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && wr_signal) |=> signal_q);
    // R10
    swrst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> $stable(swrst_q));
endmodule

// File: rtl/stacked_irq_status.sv
// Top: two stacked event stores, the summary byte and the registered interrupt.
// Assumes the read strobes are decoded host reads of the detailed status words.
module stacked_irq_status
    import stacked_irq_pkg::*;
#(
    parameter int DMA_W = 8,
    parameter int BUS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DMA_W-1:0]  dma_evt,
    input  logic [BUS_W-1:0]  bus_evt,
    input  logic [BUS_W-1:0]  bus_evt_mask,
    input  logic              irq_mask,
    input  logic              dma_stat_rd,
    input  logic              bus_stat_rd,
    input  logic              host_wr,
    input  logic [STAT_W-1:0] host_wdata,
    input  logic              abort_ack,
    input  logic              sigp_ack,
    input  logic              link_connected,
    output logic [STAT_W-1:0] istat,
    output logic [DMA_W-1:0]  dma_stat,
    output logic [BUS_W-1:0]  bus_stat,
    output logic              irq
);
    logic dma_pend, bus_pend, gate_closed;
    logic abort_q, swrst_q, signal_q, link_q;

    // Summary bits and the shared gate that closes both stores.
    always_comb begin
        dma_pend    = |dma_stat;
        bus_pend    = |(bus_stat & ~bus_evt_mask);
        gate_closed = dma_pend | bus_pend;
    end

    irq_stack_stage #(.W(DMA_W)) u_dma_stage (
        .clk(clk), .rst_n(rst_n), .evt(dma_evt), .gate_closed(gate_closed),
        .rd_clr(dma_stat_rd), .vis(dma_stat)
    );

    irq_stack_stage #(.W(BUS_W)) u_bus_stage (
        .clk(clk), .rst_n(rst_n), .evt(bus_evt), .gate_closed(gate_closed),
        .rd_clr(bus_stat_rd), .vis(bus_stat)
    );

    irq_ctrl_flags u_flags (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr),
        .wr_abort(host_wdata[STAT_ABORT]), .wr_swrst(host_wdata[STAT_SWRST]),
        .wr_signal(host_wdata[STAT_SIGNAL]), .abort_ack(abort_ack),
        .sigp_ack(sigp_ack), .link_connected(link_connected),
        .abort_q(abort_q), .swrst_q(swrst_q), .signal_q(signal_q), .link_q(link_q)
    );

    // Assembles the summary byte; unused positions read 0.
    always_comb begin
        istat               = '0;
        istat[STAT_ABORT]   = abort_q;
        istat[STAT_SWRST]   = swrst_q;
        istat[STAT_SIGNAL]  = signal_q;
        istat[STAT_LINK]    = link_q;
        istat[STAT_BUSPEND] = bus_pend;
        istat[STAT_DMAPEND] = dma_pend;
    end

    // Registered interrupt request, one cycle behind the summary.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= gate_closed & ~irq_mask;
    end

    // R7
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |=> !irq);
    // R7
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((istat[STAT_DMAPEND] || istat[STAT_BUSPEND]) && !irq_mask) |=> irq);
    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (istat[4] == 1'b0) && (istat[2] == 1'b0));
endmodule

// File: tb/stacked_irq_status_test.sv
module stacked_irq_status_test;
    localparam int DW = 8;
    localparam int BW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DW-1:0] dma_evt = '0;
    logic [BW-1:0] bus_evt = '0, bus_evt_mask = '0;
    logic irq_mask = 1'b0, dma_stat_rd = 1'b0, bus_stat_rd = 1'b0;
    logic host_wr = 1'b0, abort_ack = 1'b0, sigp_ack = 1'b0, link_connected = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] istat;
    logic [DW-1:0] dma_stat;
    logic [BW-1:0] bus_stat;
    logic irq;

    int checks = 0, fails = 0;
    bit done = 0;

    // Reference state
    logic [DW-1:0] m_dv, m_dp;
    logic [BW-1:0] m_bv, m_bp;
    logic m_abrt, m_rst, m_sigp, m_con, m_irq;

    stacked_irq_status #(.DMA_W(DW), .BUS_W(BW)) uut (
        .clk(clk), .rst_n(rst_n), .dma_evt(dma_evt), .bus_evt(bus_evt),
        .bus_evt_mask(bus_evt_mask), .irq_mask(irq_mask), .dma_stat_rd(dma_stat_rd),
        .bus_stat_rd(bus_stat_rd), .host_wr(host_wr), .host_wdata(host_wdata),
        .abort_ack(abort_ack), .sigp_ack(sigp_ack), .link_connected(link_connected),
        .istat(istat), .dma_stat(dma_stat), .bus_stat(bus_stat), .irq(irq)
    );

    always #2 clk = ~clk;

    function automatic logic exp_sip();
        return |(m_bv & ~bus_evt_mask);
    endfunction

    function automatic logic [7:0] exp_istat();
        return {m_abrt, m_rst, m_sigp, 1'b0, m_con, 1'b0, exp_sip(), |m_dv};
    endfunction

    task automatic model_reset();
        m_dv = '0; m_dp = '0; m_bv = '0; m_bp = '0;
        m_abrt = 0; m_rst = 0; m_sigp = 0; m_con = 0; m_irq = 0;
    endtask

    // Advance the model by one edge using the inputs now applied.
    task automatic model_step();
        logic closed;
        closed = exp_sip() | (|m_dv);
        m_irq = closed & ~irq_mask;
        if (dma_stat_rd) begin m_dv = m_dp; m_dp = dma_evt; end
        else if (closed) m_dp = m_dp | dma_evt;
        else begin m_dv = m_dv | m_dp | dma_evt; m_dp = '0; end
        if (bus_stat_rd) begin m_bv = m_bp; m_bp = bus_evt; end
        else if (closed) m_bp = m_bp | bus_evt;
        else begin m_bv = m_bv | m_bp | bus_evt; m_bp = '0; end
        if (host_wr && host_wdata[7]) m_abrt = 1;
        else if (abort_ack) m_abrt = 0;
        if (host_wr && host_wdata[5]) m_sigp = 1;
        else if (sigp_ack) m_sigp = 0;
        if (host_wr) m_rst = host_wdata[6];
        m_con = link_connected;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R3/R8/R9/R10/R11 istat", {24'd0, istat}, {24'd0, exp_istat()});
        chk("R2/R4/R5/R6 dma_stat", {24'd0, dma_stat}, {24'd0, m_dv});
        chk("R2/R4/R5/R6 bus_stat", {24'd0, bus_stat}, {24'd0, m_bv});
        chk("R7 irq", {31'd0, irq}, {31'd0, m_irq});
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic drive(input logic [DW-1:0] de, input logic [BW-1:0] be,
                         input logic rdd, input logic rdb, input logic wr,
                         input logic [7:0] wd, input logic aa, input logic sa);
        dma_evt = de; bus_evt = be; dma_stat_rd = rdd; bus_stat_rd = rdb;
        host_wr = wr; host_wdata = wd; abort_ack = aa; sigp_ack = sa;
        tick();
        dma_evt = '0; bus_evt = '0; dma_stat_rd = 0; bus_stat_rd = 0;
        host_wr = 0; host_wdata = '0; abort_ack = 0; sigp_ack = 0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_up();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        dma_evt = 8'hff; host_wr = 1; host_wdata = 8'hff; link_connected = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        dma_evt = '0; host_wr = 0; host_wdata = '0; link_connected = 0;
        // R1: reset state
        chk("R1 istat", {24'd0, istat}, 32'd0);
        chk("R1 dma_stat", {24'd0, dma_stat}, 32'd0);
        chk("R1 bus_stat", {24'd0, bus_stat}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rst_n = 1;
        tick();

        // R2: event while open reaches visible word
        drive(8'h04, '0, 0, 0, 0, 8'h00, 0, 0);
        chk("R2 dma visible", {24'd0, dma_stat}, 32'h04);
        tick();
        chk("R7 irq follows", {31'd0, irq}, 32'd1);
        // R4: stacked while closed
        drive(8'h10, 8'h01, 0, 0, 0, 8'h00, 0, 0);
        chk("R4 dma held", {24'd0, dma_stat}, 32'h04);
        chk("R4 bus held", {24'd0, bus_stat}, 32'h00);
        // R5: read promotes pending, summary rises again
        drive('0, '0, 1, 0, 0, 8'h00, 0, 0);
        chk("R5 dma promoted", {24'd0, dma_stat}, 32'h10);
        chk("R5 summary again", {31'd0, istat[0]}, 32'd1);
        // R6: event in the same cycle as read
        drive(8'h80, '0, 1, 0, 0, 8'h00, 0, 0);
        chk("R6 cleared", {24'd0, dma_stat}, 32'h00);
        tick();
        chk("R6 bus promoted", {24'd0, bus_stat}, 32'h01);
        drive('0, '0, 0, 1, 0, 8'h00, 0, 0);
        tick();
        chk("R6 event kept", {24'd0, dma_stat}, 32'h80);
        drive('0, '0, 1, 0, 0, 8'h00, 0, 0);
        // R3: masked bus bit excluded from summary
        bus_evt_mask = 8'h02;
        drive('0, 8'h02, 0, 0, 0, 8'h00, 0, 0);
        chk("R3 masked sip", {31'd0, istat[1]}, 32'd0);
        bus_evt_mask = '0;
        tick();
        chk("R3 unmasked sip", {31'd0, istat[1]}, 32'd1);
        // R7: mask holds irq low
        irq_mask = 1;
        tick();
        chk("R7 masked irq", {31'd0, irq}, 32'd0);
        irq_mask = 0;
        drive('0, '0, 0, 1, 0, 8'h00, 0, 0);
        // R8/R9/R10
        drive('0, '0, 0, 0, 1, 8'he0, 0, 0);
        chk("R8 abort set", {31'd0, istat[7]}, 32'd1);
        chk("R9 signal set", {31'd0, istat[5]}, 32'd1);
        chk("R10 swrst set", {31'd0, istat[6]}, 32'd1);
        drive('0, '0, 0, 0, 1, 8'h40, 1, 0);
        chk("R8 abort ack", {31'd0, istat[7]}, 32'd0);
        chk("R9 signal held", {31'd0, istat[5]}, 32'd1);
        drive('0, '0, 0, 0, 1, 8'h20, 0, 1);
        chk("R9 write wins", {31'd0, istat[5]}, 32'd1);
        chk("R10 swrst cleared", {31'd0, istat[6]}, 32'd0);
        // R11
        link_connected = 1;
        tick();
        chk("R11 link", {31'd0, istat[3]}, 32'd1);

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            logic [DW-1:0] de;
            logic [BW-1:0] be;
            de = (($urandom % 4) == 0) ? DW'($urandom) & DW'($urandom) : '0;
            be = (($urandom % 4) == 0) ? BW'($urandom) & BW'($urandom) : '0;
            irq_mask = (($urandom % 8) == 0);
            link_connected = $urandom % 2;
            if (($urandom % 32) == 0) bus_evt_mask = BW'($urandom);
            drive(de, be, ($urandom % 5) == 0, ($urandom % 5) == 0,
                  ($urandom % 6) == 0, 8'($urandom), ($urandom % 4) == 0,
                  ($urandom % 4) == 0);
        end
        finish_up();
    end
endmodule